// File: doc/BRIEF.md
# Stack Pointer Delta Tracker

This unit sits behind the instruction decoder and absorbs the implicit stack-pointer arithmetic of push, pop, call and return. Each of these moves the stack pointer by its operand size. Without this unit, each one needs its own pointer-update micro-op in the integer execution units. Here a small adder in the front end keeps a running signed offset from the last committed stack pointer, so a tracked stack instruction emits no update micro-op.

Every stack access leaves the unit tagged with the offset that held before that instruction's own adjustment. A later address stage adds this tag to the committed pointer. The pending offset must sometimes be folded into the real register. This happens when an instruction names the stack pointer explicitly while the offset is nonzero, or when the next adjustment would leave the signed range. In that slot the unit raises a request to insert one synchronisation micro-op that carries the pending offset, and it restarts from zero. A pipeline flush discards the pending offset. Two counters keep running totals of absorbed stack instructions and inserted synchronisation micro-ops.

Top module: `sp_delta_tracker`

## Requirements
- R1: After reset the pending offset is zero and both counters read zero.
- R2: `in_kind` encodes 1 = push, 2 = pop, 3 = call, 4 = return; 0 and 5..7 are non-stack. `in_wide` = 1 selects 4 bytes, 0 selects 2 bytes. Push and call subtract the size from the offset, while pop and return add it.
- R3: In the same cycle as the instruction, `acc_valid` is high for an accepted stack instruction. `acc_offset` (two's complement) carries the offset in effect before that instruction's own update.
- R4: A tracked stack instruction raises no synchronisation request unless R5 or R7 applies, and it increments `absorbed_cnt` by one.
- R5: An accepted instruction with `in_sp_explicit` high while the offset is nonzero raises `sync_req` with `sync_offset` equal to the pending offset. The offset is then treated as zero. If the instruction is also a stack operation, its tag is 0 and its own update is applied from zero.
- R6: An explicit stack-pointer instruction arriving while the offset is zero raises no synchronisation request.
- R7: A stack update that would take the 8-bit signed offset outside -128..127 first raises `sync_req` with the pre-update offset. It is then tagged 0 and applied from zero.
- R8: With `flush` high, that cycle's input is dropped: no access, no request, no count. The offset is zero from the next clock.
- R9: `sync_cnt` increments once for every cycle in which `sync_req` is high.
- R10: With `in_valid` low, or with a non-stack, non-explicit kind, the offset and the counters keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop this cycle's input and clear the offset |
| in_valid | input | 1 | A decoded instruction is present |
| in_kind | input | 3 | Instruction kind (see R2) |
| in_wide | input | 1 | Operand size: 1 = 4 bytes, 0 = 2 bytes |
| in_sp_explicit | input | 1 | Instruction reads or writes the stack pointer by name |
| acc_valid | output | 1 | A stack memory access is issued this cycle |
| acc_offset | output | 8 | Signed offset tag for the access |
| sync_req | output | 1 | Insert a synchronisation micro-op ahead of this instruction |
| sync_offset | output | 8 | Pending offset to commit with the synchronisation micro-op |
| absorbed_cnt | output | 16 | Total of stack instructions absorbed |
| sync_cnt | output | 16 | Total of synchronisation micro-ops requested |

## Verification
The bench targets the limits of the signed range. A push that lands exactly on -128 must pass without a request, and the one after it must force one. A pop reaching +128 must likewise force a request. A design that checks overflow after the update, or against the wrong bound, would either tag with a wrapped offset or commit too early. Explicit stack-pointer use is probed both with a zero offset, where a wrong design would insert a needless micro-op, and with a nonzero offset on a push, where the tag must restart at zero. Flushing in the same cycle as a push checks that the squashed instruction neither counts nor leaks into the next offset.

// File: rtl/sp_trk_pkg.sv
package sp_trk_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4
    } stk_op_e;

    typedef struct packed {
        logic is_stack;  // push, pop, call or return
        logic down;      // pointer moves toward lower addresses
        logic wide;      // 4-byte operand
    } stk_dec_t;

    localparam int unsigned NARROW_BYTES = 2;
    localparam int unsigned WIDE_BYTES   = 4;

    function automatic stk_dec_t decode_kind(input logic [2:0] kind, input logic wide);
        stk_dec_t d;
        d.wide = wide;
        unique case (kind)
            OP_PUSH, OP_CALL: begin d.is_stack = 1'b1; d.down = 1'b1; end
            OP_POP,  OP_RET:  begin d.is_stack = 1'b1; d.down = 1'b0; end
            default:          begin d.is_stack = 1'b0; d.down = 1'b0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sp_trk_decode.sv
module sp_trk_decode
    import sp_trk_pkg::*;
(
    input  logic       in_valid,
    input  logic [2:0] in_kind,
    input  logic       in_wide,
    input  logic       flush,
    output logic       live,
    output stk_dec_t   dec
);
    always_comb begin
        live = in_valid && !flush;
        dec  = decode_kind(in_kind, in_wide);
        if (!live) begin
            dec.is_stack = 1'b0;
        end
    end
endmodule

// File: rtl/sp_trk_delta.sv
module sp_trk_delta
    import sp_trk_pkg::*;
#(
    parameter int unsigned OFF_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    live,
    input  stk_dec_t                dec,
    input  logic                    sp_explicit,
    output logic signed [OFF_W-1:0] base_off,
    output logic                    sync_req,
    output logic signed [OFF_W-1:0] sync_off
);
    localparam int unsigned SUM_W = OFF_W + 1;

    logic signed [OFF_W-1:0] off_q;
    logic signed [SUM_W-1:0] step;
    logic signed [SUM_W-1:0] trial;
    logic signed [SUM_W-1:0] sum;
    logic                    expl_sync;
    logic                    ovf;

    always_comb begin
        step = dec.wide ? SUM_W'(WIDE_BYTES) : SUM_W'(NARROW_BYTES);
        if (dec.down) begin
            step = -step;
        end
        if (!dec.is_stack) begin
            step = '0;
        end
        expl_sync = live && sp_explicit && (off_q != '0);
        trial     = SUM_W'(off_q) + step;
        ovf       = dec.is_stack && (trial[SUM_W-1] != trial[SUM_W-2]);
        sync_req  = expl_sync || ovf;
        sync_off  = off_q;
        base_off  = sync_req ? '0 : off_q;
        sum       = SUM_W'(base_off) + step;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            off_q <= '0;
        end else if (dec.is_stack) begin
            off_q <= sum[OFF_W-1:0];
        end else if (sync_req) begin
            off_q <= '0;
        end
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (off_q == '0)); // R8

    AST_STEP_APPLIED: assert property (@(posedge clk) disable iff (rst)
        (live && dec.is_stack && !sync_req && !flush)
            |=> (off_q == $past(off_q) + $past(step[OFF_W-1:0]))); // R2

    AST_SYNC_NONZERO: assert property (@(posedge clk) disable iff (rst)
        sync_req |-> (sync_off != '0)); // R5

    AST_EXPL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (live && sp_explicit && !dec.is_stack) |=> (off_q == '0)); // R5

    AST_EXPL_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (live && sp_explicit && !dec.is_stack && (off_q == '0)) |-> !sync_req); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!live && !flush) |=> (off_q == $past(off_q))); // R10
endmodule

// File: rtl/sp_trk_count.sv
module sp_trk_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        inc |=> (cnt == $past(cnt) + CNT_W'(1))); // R4 R9

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt)); // R10
endmodule

// File: rtl/sp_delta_tracker.sv
module sp_delta_tracker
    import sp_trk_pkg::*;
#(
    parameter int unsigned OFF_W = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [2:0]       in_kind,
    input  logic             in_wide,
    input  logic             in_sp_explicit,
    output logic             acc_valid,
    output logic [OFF_W-1:0] acc_offset,
    output logic             sync_req,
    output logic [OFF_W-1:0] sync_offset,
    output logic [CNT_W-1:0] absorbed_cnt,
    output logic [CNT_W-1:0] sync_cnt
);
    localparam int unsigned N_CNT = 2;

    logic                    live;
    stk_dec_t                dec;
    logic signed [OFF_W-1:0] base_off;
    logic signed [OFF_W-1:0] sync_off;
    logic [N_CNT-1:0]        cnt_inc;
    logic [CNT_W-1:0]        cnt_val [N_CNT];

    sp_trk_decode u_decode (
        .in_valid (in_valid),
        .in_kind  (in_kind),
        .in_wide  (in_wide),
        .flush    (flush),
        .live     (live),
        .dec      (dec)
    );

    sp_trk_delta #(.OFF_W(OFF_W)) u_delta (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .live        (live),
        .dec         (dec),
        .sp_explicit (in_sp_explicit),
        .base_off    (base_off),
        .sync_req    (sync_req),
        .sync_off    (sync_off)
    );

    assign cnt_inc[0] = dec.is_stack;
    assign cnt_inc[1] = sync_req;

    for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
        sp_trk_count #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .inc (cnt_inc[gi]),
            .cnt (cnt_val[gi])
        );
    end

    assign acc_valid    = dec.is_stack;
    assign acc_offset   = base_off;
    assign sync_offset  = sync_off;
    assign absorbed_cnt = cnt_val[0];
    assign sync_cnt     = cnt_val[1];

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!acc_valid && !sync_req)); // R8
endmodule

// File: tb/sp_delta_tracker_tb.sv
`timescale 1ns/1ps
module sp_delta_tracker_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        in_valid;
    logic [2:0]  in_kind;
    logic        in_wide;
    logic        in_sp_explicit;
    logic        acc_valid;
    logic [7:0]  acc_offset;
    logic        sync_req;
    logic [7:0]  sync_offset;
    logic [15:0] absorbed_cnt;
    logic [15:0] sync_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sp_delta_tracker u_dut (
        .clk            (clk),
        .rst            (rst),
        .flush          (flush),
        .in_valid       (in_valid),
        .in_kind        (in_kind),
        .in_wide        (in_wide),
        .in_sp_explicit (in_sp_explicit),
        .acc_valid      (acc_valid),
        .acc_offset     (acc_offset),
        .sync_req       (sync_req),
        .sync_offset    (sync_offset),
        .absorbed_cnt   (absorbed_cnt),
        .sync_cnt       (sync_cnt)
    );

    // {valid, kind[3], wide, expl, flush, exp_acc, exp_tag[8], exp_sync, exp_soff[8]}
    localparam int NV = 12;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00}, // push4  -> -4
        {1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFC, 1'b0, 8'h00}, // push2  -> -6
        {1'b1, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFA, 1'b0, 8'h00}, // call4  -> -10
        {1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 8'hF6, 1'b0, 8'h00}, // pop2   -> -8
        {1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 8'hF8, 1'b0, 8'h00}, // ret4   -> -4
        {1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFC, 1'b0, 8'h00}, // other  -> -4
        {1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'hFC}, // expl   -> 0
        {1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}, // expl@0 -> 0
        {1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00}, // pop4   -> 4
        {1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h04}, // push4 expl -> -4
        {1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFC, 1'b0, 8'h00}, // idle   -> -4
        {1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFC, 1'b0, 8'h00}  // pop4   -> 0
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] k, input logic w,
                         input logic e, input logic f);
        @(negedge clk);
        in_valid = v; in_kind = k; in_wide = w; in_sp_explicit = e; flush = f;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_kind = 3'd0; in_wide = 1'b0;
        in_sp_explicit = 1'b0; flush = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        idle();
        chk("R1", "absorbed_cnt", 32'(absorbed_cnt), 32'd0);
        chk("R1", "sync_cnt", 32'(sync_cnt), 32'd0);
        chk("R1", "offset", 32'(acc_offset), 32'h00);

        // Vector table: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            drive(v[24], v[23:21], v[20], v[19], v[18]);
            chk("R3", $sformatf("acc_valid vec %0d", i), 32'(acc_valid), 32'(v[17]));
            chk("R2/R3", $sformatf("acc_offset vec %0d", i), 32'(acc_offset), 32'(v[16:9]));
            chk("R4/R5/R6", $sformatf("sync_req vec %0d", i), 32'(sync_req), 32'(v[8]));
            if (v[8]) begin
                chk("R5", $sformatf("sync_offset vec %0d", i), 32'(sync_offset), 32'(v[7:0]));
            end
        end
        idle();
        chk("R4", "absorbed total", 32'(absorbed_cnt), 32'd8);
        chk("R9", "sync total", 32'(sync_cnt), 32'd2);
        chk("R10", "offset after table", 32'(acc_offset), 32'h00);

        // R7: push down to exactly -128, then one more
        do_reset();
        for (int i = 0; i < 32; i++) begin
            drive(1'b1, 3'd1, 1'b1, 1'b0, 1'b0);
            if (sync_req) begin
                chk("R7", $sformatf("early sync at push %0d", i), 32'd1, 32'd0);
            end
        end
        drive(1'b1, 3'd1, 1'b1, 1'b0, 1'b0);
        chk("R7", "sync at -132", 32'(sync_req), 32'd1);
        chk("R7", "sync_offset -128", 32'(sync_offset), 32'h80);
        chk("R7", "tag after forced sync", 32'(acc_offset), 32'h00);
        idle();
        chk("R7", "offset restarted", 32'(acc_offset), 32'hFC);
        chk("R9", "sync count overflow", 32'(sync_cnt), 32'd1);
        chk("R4", "absorbed count overflow", 32'(absorbed_cnt), 32'd33);

        // R7: pop up past +127
        do_reset();
        for (int i = 0; i < 31; i++) begin
            drive(1'b1, 3'd2, 1'b1, 1'b0, 1'b0);
        end
        drive(1'b1, 3'd2, 1'b1, 1'b0, 1'b0);
        chk("R7", "sync at +128", 32'(sync_req), 32'd1);
        chk("R7", "sync_offset +124", 32'(sync_offset), 32'h7C);
        idle();
        chk("R7", "offset after pop overflow", 32'(acc_offset), 32'h04);

        // R8: flush with a push in the same cycle
        do_reset();
        drive(1'b1, 3'd1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 3'd1, 1'b1, 1'b1, 1'b1);
        chk("R8", "acc_valid under flush", 32'(acc_valid), 32'd0);
        chk("R8", "sync_req under flush", 32'(sync_req), 32'd0);
        idle();
        chk("R8", "offset after flush", 32'(acc_offset), 32'h00);
        chk("R8", "absorbed after flush", 32'(absorbed_cnt), 32'd1);
        chk("R8", "sync after flush", 32'(sync_cnt), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule